// File: doc/BRIEF.md
# Static RAM Wait-State Controller

This block turns single-beat requests from an internal port into access cycles on an asynchronous 32K x 8 static RAM. It drives active-low chip select, write enable and output enable, fifteen address lines and a shared eight-bit data bus. Every access is accepted only while the controller is idle. The port's ready output pulses once when the access has finished, and read data is valid in that same cycle.

The block runs on a phase clock `clk` at twice the memory bus rate, so one phase is half a bus clock. Strobe edges can therefore land on half-cycle boundaries. A three-bit wait count is sampled when a request is accepted, and it stretches the cycle from there:
- The chip-select and address window grows by one full bus clock (two phases) per wait state.
- The write-enable pulse and the write-data window grow by half a bus clock (one phase) per wait state.

With a 25 ns bus clock, a wait count of 2 gives a 75 ns address window. This covers write-cycle-time needs of 55 ns and 70 ns.

The controller keeps every ordering of accesses free of bus contention. Between accesses there are always at least two phases with chip select high and the bus released. A write that follows a read gets one more released phase, so that the memory's output drivers can turn off first.

Top module: `sram_wait_ctrl`

## Requirements
- R1: While `rst` is high, and from the moment it is raised during an access, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, `req_ready` is 0 and `sram_dq` is not driven. After release, a new request is served normally.
- R2: For wait count W, chip select is low for exactly 2+2W consecutive phases per access. `sram_addr` equals the request address throughout that window.
- R3: In a write, write enable falls exactly one phase after chip select falls. It stays low for 1+W phases and is only ever low while chip select is low.
- R4: In a write, the controller drives the request's write data onto `sram_dq` for 2+W phases, starting in the first chip-select phase. It drives nothing outside the chip-select window.
- R5: In a read, output enable is low for the whole 2+2W-phase chip-select window, write enable stays high, and the controller never drives `sram_dq`.
- R6: Read data is sampled from `sram_dq` at the end of the last chip-select phase. It appears on `rsp_rdata` while `req_ready` is high.
- R7: `req_ready` is high for exactly one phase, in the first phase after chip select rises. A request is accepted only from idle, each request yields exactly one chip-select window, and with no request the outputs stay inactive.
- R8: `cfg_wait` is sampled when the request is accepted. Changing it during an access has no effect on that access's timing.
- R9: Between back-to-back accesses, chip select is high for exactly two phases (ready phase plus idle phase). A write that follows a read gets exactly three phases instead, and the bus is released in each of them.
- R10: Output enable and the controller's data drivers are never active in the same phase. The controller does not drive the bus in the phase in which output enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the memory bus rate |
| rst | input | 1 | Asynchronous reset, active high |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| cfg_wait | input | 3 | Wait-state count, sampled at acceptance |
| req_ready | output | 1 | One-phase completion pulse |
| rsp_rdata | output | 8 | Captured read data |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | 15 | Memory address lines |
| sram_dq | inout | 8 | Bidirectional data bus |

## Verification
The bench builds the block with its default parameters: 15 address bits, 8 data bits and a 3-bit wait count. This lets the table cover the shortest cycle (W=0), the timing target (W=2) and the longest stretch (W=7), with phase counts measured at the memory pins. A small memory model on a pulled-up bus shows which phases the controller drives. Chained requests reach every read/write ordering, including the extra turnaround gap. Two entries change `cfg_wait` in mid-access, and a reset is raised during a write strobe.

// File: rtl/sram_wait_pkg.sv
package sram_wait_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RDACC,
        ST_DONE
    } sram_state_e;

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int WS_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [WS_W-1:0]   ws_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [WS_W-1:0]   ws_q
);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            ws_q    <= '0;
        end else if (load) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
            ws_q    <= ws_in;
        end
    end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            dout <= '0;
        else if (en)
            dout <= din;
    end

endmodule

// File: rtl/sram_wait_ctrl.sv
module sram_wait_ctrl
    import sram_wait_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int WS_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WS_W-1:0]   cfg_wait,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_dq
);

    localparam int CNT_W = WS_W + 1;

    sram_state_e       state_q, state_d;
    logic              accept;
    logic              t_load, t_zero;
    logic [CNT_W-1:0]  t_val;
    logic              capture;
    logic              drv_en;
    logic              last_rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [WS_W-1:0]   ws_q;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = (state_q == ST_RDACC) && t_zero;

    sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .ws_in    (cfg_wait),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .ws_q     (ws_q)
    );

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_rdcap (
        .clk  (clk),
        .rst  (rst),
        .en   (capture),
        .din  (sram_dq),
        .dout (rsp_rdata)
    );

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // remembers that the bus was last turned toward the memory
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            last_rd_q <= 1'b0;
        else if (state_q == ST_RDACC)
            last_rd_q <= 1'b1;
        else if (state_q == ST_SETUP)
            last_rd_q <= 1'b0;
    end

    // next state and phase-timer loads
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = last_rd_q ? ST_TURN : ST_SETUP;
                    end else begin
                        state_d = ST_RDACC;
                        t_load  = 1'b1;
                        t_val   = {cfg_wait, 1'b1};
                    end
                end
            end
            ST_TURN:  state_d = ST_SETUP;
            ST_SETUP: begin
                state_d = ST_STROBE;
                t_load  = 1'b1;
                t_val   = CNT_W'(ws_q);
            end
            ST_STROBE: begin
                if (t_zero) begin
                    if (ws_q == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_HOLD;
                        t_load  = 1'b1;
                        t_val   = CNT_W'(ws_q) - 1'b1;
                    end
                end
            end
            ST_HOLD:  if (t_zero) state_d = ST_DONE;
            ST_RDACC: if (t_zero) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs per state
    always_comb begin
        sram_cs_n = 1'b1;
        sram_we_n = 1'b1;
        sram_oe_n = 1'b1;
        drv_en    = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TURN: ;
            ST_SETUP: begin
                sram_cs_n = 1'b0;
                drv_en    = 1'b1;
            end
            ST_STROBE: begin
                sram_cs_n = 1'b0;
                sram_we_n = 1'b0;
                drv_en    = 1'b1;
            end
            ST_HOLD:  sram_cs_n = 1'b0;
            ST_RDACC: begin
                sram_cs_n = 1'b0;
                sram_oe_n = 1'b0;
            end
            ST_DONE:  req_ready = 1'b1;
            default: ;
        endcase
    end

    assign sram_addr = addr_q;
    assign sram_dq   = drv_en ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_wait_ctrl_chk.sv
module sram_wait_ctrl_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              ready,
    input logic              drv_en,
    input logic [ADDR_W-1:0] addr
);

    assert_we_inside_cs_R3: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !cs_n);

    assert_we_after_cs_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> !$past(cs_n));

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n)) |-> $stable(addr));

    assert_drive_in_window_R4: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> !cs_n);

    assert_oe_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> we_n);

    assert_ready_single_R7: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    assert_ready_idle_bus_R7: assert property (@(posedge clk) disable iff (rst)
        ready |-> cs_n);

    assert_no_contention_R10: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !drv_en);

    assert_release_after_read_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_n) |-> !drv_en);

endmodule

bind sram_wait_ctrl sram_wait_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (sram_cs_n),
    .we_n   (sram_we_n),
    .oe_n   (sram_oe_n),
    .ready  (req_ready),
    .drv_en (drv_en),
    .addr   (sram_addr)
);

// File: tb/sram_wait_ctrl_test.sv
module sram_wait_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [2:0]  cfg_wait = '0;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic        sram_cs_n, sram_we_n, sram_oe_n;
    logic [14:0] sram_addr;
    tri1  [7:0]  dq;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem [16];
    logic [7:0] exp_mem [16];

    always #4 clk = ~clk;

    sram_wait_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cfg_wait  (cfg_wait),
        .req_ready (req_ready),
        .rsp_rdata (rsp_rdata),
        .sram_cs_n (sram_cs_n),
        .sram_we_n (sram_we_n),
        .sram_oe_n (sram_oe_n),
        .sram_addr (sram_addr),
        .sram_dq   (dq)
    );

    // small memory model: drives when selected and output-enabled
    assign dq = (!sram_cs_n && !sram_oe_n) ? mem[sram_addr[3:0]] : 8'bz;

    always @(negedge clk)
        if (!sram_cs_n && !sram_we_n)
            mem[sram_addr[3:0]] <= dq;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // {write, wait[2:0], flip, pre[1:0], addr[14:0], wdata[7:0]}
    localparam logic [29:0] VEC [12] = '{
        {1'b1, 3'd0, 1'b0, 2'd0, 15'h0001, 8'hA5},
        {1'b1, 3'd2, 1'b0, 2'd1, 15'h7FF2, 8'h3C},
        {1'b0, 3'd0, 1'b0, 2'd1, 15'h0001, 8'h00},
        {1'b0, 3'd2, 1'b0, 2'd1, 15'h7FF2, 8'h00},
        {1'b1, 3'd1, 1'b0, 2'd2, 15'h0003, 8'h5A},
        {1'b1, 3'd7, 1'b0, 2'd1, 15'h4004, 8'h7E},
        {1'b0, 3'd7, 1'b0, 2'd1, 15'h4004, 8'h00},
        {1'b1, 3'd3, 1'b1, 2'd2, 15'h0005, 8'h00},
        {1'b0, 3'd1, 1'b1, 2'd1, 15'h0005, 8'h00},
        {1'b0, 3'd5, 1'b0, 2'd1, 15'h0003, 8'h00},
        {1'b1, 3'd4, 1'b0, 2'd2, 15'h1006, 8'h81},
        {1'b0, 3'd2, 1'b0, 2'd1, 15'h1006, 8'h00}
    };

    // called at a falling edge; returns at the falling edge where ready is seen
    task automatic run_access(input logic wr, input logic [2:0] ws, input logic flip,
                              input int pre_exp, input logic [14:0] addr,
                              input logic [7:0] wd, input logic [7:0] rd_exp);
        int  pre = 0, cs_cnt = 0, we_cnt = 0, oe_cnt = 0, drv = 0, lead = -1;
        int  bad_addr = 0, bad_data = 0, cs_windows = 0;
        bit  seen_cs = 0, done = 0, prev_cs_low = 0, ready_ok = 0, flipped = 0;
        logic [7:0] rd_s = '0;
        string tw;
        tw = flip ? "R8" : "R2";
        req_write = wr; req_addr = addr; req_wdata = wd; cfg_wait = ws; req_valid = 1'b1;
        for (int i = 0; i < 64 && !done; i++) begin
            @(negedge clk);
            if (!seen_cs && sram_cs_n) pre++;
            if (!sram_cs_n) begin
                if (!prev_cs_low) cs_windows++;
                seen_cs = 1;
                cs_cnt++;
                if (sram_addr !== addr) bad_addr++;
                if (flip && !flipped) begin cfg_wait = ~ws; flipped = 1; end
                if (!sram_we_n) begin
                    we_cnt++;
                    if (we_cnt == 1) lead = cs_cnt - 1;
                end
                if (!sram_oe_n) oe_cnt++;
            end
            if (sram_oe_n && dq != 8'hFF) begin
                drv++;
                if (dq !== wd || sram_cs_n) bad_data++;
            end
            if (req_ready) begin
                done = 1;
                ready_ok = prev_cs_low && sram_cs_n;
                rd_s = rsp_rdata;
                req_valid = 1'b0;
                cfg_wait = ws;
            end
            prev_cs_low = !sram_cs_n;
        end
        check(done, "R7 ready seen", int'(done), 1);
        check(ready_ok, "R7 ready right after cs window", int'(ready_ok), 1);
        check(cs_windows == 1, "R7 one cs window", cs_windows, 1);
        check(pre == pre_exp, (pre_exp == 2) ? "R9 turnaround gap" : "R9 gap", pre, pre_exp);
        check(cs_cnt == 2 + 2 * ws, {tw, " cs width"}, cs_cnt, 2 + 2 * ws);
        check(bad_addr == 0, "R2 address held", bad_addr, 0);
        if (wr) begin
            check(lead == 1, "R3 we setup phase", lead, 1);
            check(we_cnt == 1 + ws, flip ? "R8 we width" : "R3 we width", we_cnt, 1 + ws);
            check(drv == 2 + ws, "R4 data drive phases", drv, 2 + ws);
            check(bad_data == 0, "R4 data value", bad_data, 0);
            check(oe_cnt == 0, "R5 oe idle on write", oe_cnt, 0);
        end else begin
            check(oe_cnt == 2 + 2 * ws, flip ? "R8 oe width" : "R5 oe width", oe_cnt, 2 + 2 * ws);
            check(we_cnt == 0, "R5 we idle on read", we_cnt, 0);
            check(drv == 0, "R5 no drive on read", drv, 0);
            check(rd_s == rd_exp, "R6 read data", rd_s, rd_exp);
        end
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        check(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes idle in reset", 0, 1);
        check(!req_ready, "R1 ready low in reset", int'(req_ready), 0);
        check(dq == 8'hFF, "R1 bus released in reset", int'(dq), 255);
        rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            logic [29:0] v;
            logic [7:0]  rexp;
            v = VEC[i];
            rexp = exp_mem[v[11:8]];
            run_access(v[29], v[28:26], v[25], int'(v[24:23]), v[22:8], v[7:0], rexp);
            if (v[29]) exp_mem[v[11:8]] = v[7:0];
        end

        // R7: nothing happens without a request
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(sram_cs_n && !req_ready, "R7 idle without request", int'(sram_cs_n), 1);
        end

        // R1: reset raised in the middle of a write strobe
        req_write = 1'b1; req_addr = 15'h0007; req_wdata = 8'h42; cfg_wait = 3'd3;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(!sram_we_n, "R1 write strobe active before reset", int'(sram_we_n), 0);
        req_valid = 1'b0;
        rst = 1'b1;
        #2;
        check(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes idle after mid reset", 0, 1);
        check(dq == 8'hFF && !req_ready, "R1 bus released after mid reset", int'(dq), 255);
        @(negedge clk);
        rst = 1'b0;
        run_access(1'b0, 3'd0, 1'b0, 0, 15'h0001, 8'h00, exp_mem[1]);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule